// File: doc/BRIEF.md
# UART Register Front-End with Receive Queue

This block is the bus-facing half of a UART-style peripheral. It is an APB slave with a small register window: a data port, a status word, a control word, and two placeholder locations that read as zero. The serial line, the baud generator and any FIFO debug path live elsewhere. Received bytes come in on a valid/ready byte input and are stored in a receive queue. The CPU drains the queue by reading the data port. A CPU write to the data port sends one byte out on a byte output.

One interrupt line gives a single-cycle pulse when a byte is accepted with receive interrupts enabled, or when a byte is sent with transmit interrupts enabled. The receive queue counts capacity from its write position, not from its occupancy. After the CPU has read the queue fully empty, both positions rewind to zero and the full capacity becomes available again.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x0000_0006, control reads 0, the queue is empty, rx_ready is 1, and irq and tx_valid are 0.
- R2: Only paddr[7:0] is decoded. Data is at 0x00 and also at 0x03, status at 0x04, control at 0x08. The scaler (0x0C), the debug location (0x10) and every other offset read 0, and writes to them change nothing. prdata is 0 outside read access cycles.
- R3: The control register takes all 32 bits of a write and reads them back unchanged.
- R4: Status is read-only, and writes to 0x04 are ignored. Bit 1 (transmit shift empty) and bit 2 (transmit FIFO empty) always read 1. Bits 3 to 31 always read 0.
- R5: A handshaken input byte (rx_valid and rx_ready) is stored only if control bit 0 (receive enable) was set. Otherwise the byte is consumed and discarded.
- R6: A data read returns the oldest stored byte in bits 7:0 and removes it. A data read with the queue empty returns 0 and changes nothing.
- R7: Reading the last stored byte, with no byte arriving in the same cycle, returns the write position to zero so that rx_ready rises again. Reading fewer bytes than were stored does not restore rx_ready.
- R8: rx_ready is 0 once the write position has reached the queue depth (default 1024), and 1 otherwise.
- R9: A data write sends wdata[7:0] only if control bit 1 (transmit enable) is set and tx_ready is 1 in the access cycle. tx_valid is then high for exactly the next cycle, with tx_data holding the byte. Otherwise no byte is sent.
- R10: irq is high for one cycle after an accepted input byte when control bit 2 is set, or after a sent byte when control bit 3 is set. The two events in the same cycle give a single one-cycle pulse.
- R11: pready is always 1 and pslverr is always 0.
- R12: Status bit 0 (data ready) is 1 exactly while the queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational in the access cycle |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Space left at the queue write position |
| tx_valid | output | 1 | One-cycle outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sink present and accepting |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Most internal faults in this block become visible on the next bus read or on the next clock edge. A read or write pointer that drifts changes the value of the next data read, or lets rx_ready come back too early or too late. The earliest point where this shows is a read of the last byte, or the write that fills the queue. A data-ready flag that gets out of step with the pointers shows in the very next status read. A wrong enable gate shows up one cycle later as a missing or extra pulse on irq or tx_valid. For these reasons the bench compares every output on every cycle against a behavioural queue model. It also drives the queue all the way to full and back to empty.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

   // Register kinds produced by the decoder
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_STAT,
      SEL_CTRL,
      SEL_ZERO
   } regsel_e;

   // Control bit positions that the logic consumes
   localparam int unsigned CB_RX_EN  = 0;
   localparam int unsigned CB_TX_EN  = 1;
   localparam int unsigned CB_RX_IRQ = 2;
   localparam int unsigned CB_TX_IRQ = 3;

   // Status bit positions
   localparam int unsigned SB_DREADY  = 0;
   localparam int unsigned SB_TSHIFT  = 1;
   localparam int unsigned SB_TFIFO   = 2;

   localparam logic [31:0] STAT_FIXED = (32'd1 << SB_TSHIFT) | (32'd1 << SB_TFIFO);

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] paddr,
   output regsel_e           sel
);

   localparam int NREG = 6;
   localparam logic [7:0] OFS  [NREG] = '{8'h00, 8'h03, 8'h04, 8'h08, 8'h0C, 8'h10};
   localparam regsel_e    KIND [NREG] = '{SEL_DATA, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_ZERO, SEL_ZERO};

   if (ADDR_W < 8) begin : g_bad_addr
      $error("uart_rf_decode: ADDR_W must be at least 8");
   end

   logic [NREG-1:0] hit;

   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = (paddr[7:0] == OFS[i]);
   end

   if (ADDR_W > 8) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^paddr[ADDR_W-1:8];
   end

   always_comb begin
      sel = SEL_NONE;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) sel = KIND[i];
      end
   end

endmodule

// File: rtl/uart_rf_rxq.sv
module uart_rf_rxq #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              last,
   output logic              room
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PTR_W = IDX_W + 1;
   localparam logic [PTR_W-1:0] FULL_AT = PTR_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rf_rxq: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              pop_eff;

   assign empty   = (rd_ptr == wr_ptr);
   assign last    = (rd_ptr + PTR_W'(1) == wr_ptr);
   assign room    = (wr_ptr != FULL_AT);
   assign pop_eff = pop && !empty;
   assign head    = mem[rd_ptr[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr[IDX_W-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (pop_eff && last && !push) begin
         // fully drained: rewind both positions
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push)    wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_eff) rd_ptr <= rd_ptr + PTR_W'(1);
      end
   end

   p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && last && !push) |=> (wr_ptr == '0 && rd_ptr == '0));

   p_wr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr <= FULL_AT) && (rd_ptr <= wr_ptr));

endmodule

// File: rtl/uart_rf_evt.sv
module uart_rf_evt (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_evt,
   input  logic       tx_evt,
   input  logic       rx_irq_en,
   input  logic       tx_irq_en,
   input  logic [7:0] tx_byte_in,
   output logic       irq,
   output logic       tx_valid,
   output logic [7:0] tx_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         irq      <= (rx_evt && rx_irq_en) || (tx_evt && tx_irq_en);
         tx_valid <= tx_evt;
         if (tx_evt) tx_data <= tx_byte_in;
      end
   end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int RXQ_DEPTH = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              irq
);

   regsel_e     sel;
   logic        acc, rd_acc, wr_acc;
   logic [31:0] ctrl_q;
   logic        dready_q;
   logic        q_push, q_pop, q_empty, q_last, q_room;
   logic [7:0]  q_head;
   logic        tx_send;

   assign acc    = psel && penable;
   assign rd_acc = acc && !pwrite;
   assign wr_acc = acc && pwrite;

   uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
      .paddr (paddr),
      .sel   (sel)
   );

   assign q_push  = rx_valid && q_room && ctrl_q[CB_RX_EN];
   assign q_pop   = rd_acc && (sel == SEL_DATA);
   assign tx_send = wr_acc && (sel == SEL_DATA) && ctrl_q[CB_TX_EN] && tx_ready;

   uart_rf_rxq #(.DEPTH(RXQ_DEPTH), .DATA_W(8)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (rx_data),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .last      (q_last),
      .room      (q_room)
   );

   uart_rf_evt u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_evt     (q_push),
      .tx_evt     (tx_send),
      .rx_irq_en  (ctrl_q[CB_RX_IRQ]),
      .tx_irq_en  (ctrl_q[CB_TX_IRQ]),
      .tx_byte_in (pwdata[7:0]),
      .irq        (irq),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         dready_q <= 1'b0;
      end else begin
         if (wr_acc && sel == SEL_CTRL) ctrl_q <= pwdata;
         if (q_push)
            dready_q <= 1'b1;
         else if (q_pop && (q_empty || q_last))
            dready_q <= 1'b0;
      end
   end

   always_comb begin
      prdata = '0;
      if (rd_acc) begin
         unique case (sel)
            SEL_DATA: prdata = q_empty ? 32'd0 : {24'd0, q_head};
            SEL_STAT: prdata = STAT_FIXED | (32'(dready_q) << SB_DREADY);
            SEL_CTRL: prdata = ctrl_q;
            default:  prdata = '0;
         endcase
      end
   end

   assign rx_ready = q_room;
   assign pready   = 1'b1;
   assign pslverr  = 1'b0;

   p_dready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      dready_q == !q_empty);

   p_tx_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(ctrl_q[CB_TX_EN] && tx_ready && wr_acc));

   p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ctrl_q[CB_RX_IRQ] || ctrl_q[CB_TX_IRQ]));

endmodule

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;

   localparam int DEPTH = 1024;
   localparam int WD_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 0, penable = 0, pwrite = 0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic        rx_valid = 0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;
   logic        irq;

   always #2 clk = ~clk;

   uart_regfront #(.ADDR_W(12), .RXQ_DEPTH(DEPTH)) dut_i (.*);

   int vec = 0, bad = 0;
   bit done = 0;

   // behavioural model state
   logic [7:0]  mq[$];
   int          mfill = 0;
   logic [31:0] mctrl = '0;
   logic        mirq = 0, mtxv = 0;
   logic [7:0]  mtxb = '0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, bit ps, bit pe, bit pw, logic [11:0] a,
                       logic [31:0] d, bit rxv, logic [7:0] rb, bit txr);
      logic [7:0]  off;
      bit          isdata, rd_a, wr_a, push, popdo, send, nirq;
      logic [31:0] exp_rd;
      @(negedge clk);
      psel = ps; penable = pe; pwrite = pw; paddr = a; pwdata = d;
      rx_valid = rxv; rx_data = rb; tx_ready = txr;
      off    = a[7:0];
      isdata = (off == 8'h00) || (off == 8'h03);
      rd_a   = ps && pe && !pw;
      wr_a   = ps && pe && pw;
      exp_rd = 32'd0;
      if (rd_a) begin
         if (isdata)            exp_rd = (mq.size() > 0) ? {24'd0, mq[0]} : 32'd0;
         else if (off == 8'h04) exp_rd = 32'h6 | ((mq.size() > 0) ? 32'd1 : 32'd0);
         else if (off == 8'h08) exp_rd = mctrl;
      end
      #1;
      chk(tag, "prdata", prdata, exp_rd);
      chk("R8", "rx_ready", {31'd0, rx_ready}, {31'd0, mfill < DEPTH});
      chk("R11", "pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      chk("R10", "irq", {31'd0, irq}, {31'd0, mirq});
      chk("R9", "tx_valid", {31'd0, tx_valid}, {31'd0, mtxv});
      if (mtxv) chk("R9", "tx_data", {24'd0, tx_data}, {24'd0, mtxb});
      push  = rxv && (mfill < DEPTH) && mctrl[0];
      popdo = rd_a && isdata && (mq.size() > 0);
      send  = wr_a && isdata && mctrl[1] && txr;
      nirq  = (push && mctrl[2]) || (send && mctrl[3]);
      @(posedge clk);
      mirq = nirq;
      mtxv = send;
      if (send) mtxb = d[7:0];
      if (popdo) void'(mq.pop_front());
      if (push) begin
         mq.push_back(rb);
         mfill++;
      end else if (popdo && mq.size() == 0) begin
         mfill = 0;
      end
      if (wr_a && off == 8'h08) mctrl = d;
   endtask

   task automatic idle(string tag, bit rxv = 0, logic [7:0] rb = 0, bit txr = 1);
      step(tag, 0, 0, 0, 12'h0, 32'h0, rxv, rb, txr);
   endtask

   task automatic wr(string tag, logic [11:0] a, logic [31:0] d, bit rxv = 0,
                     logic [7:0] rb = 0, bit txr = 1);
      step(tag, 1, 0, 1, a, d, 0, 0, txr);
      step(tag, 1, 1, 1, a, d, rxv, rb, txr);
   endtask

   task automatic rd(string tag, logic [11:0] a, bit rxv = 0, logic [7:0] rb = 0);
      step(tag, 1, 0, 0, a, 32'h0, 0, 0, 1);
      step(tag, 1, 1, 0, a, 32'h0, rxv, rb, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      idle("R1");
      rd("R1 status", 12'h004);
      rd("R1 control", 12'h008);
      rd("R6 empty data", 12'h000);
      // R3 control readback
      wr("R3", 12'h008, 32'hFFF0_0000);
      rd("R3", 12'h008);
      wr("R3", 12'h008, 32'h8000_0000);
      rd("R3", 12'h008);
      // R4 status read-only
      wr("R4", 12'h004, 32'hFFFF_FFFF);
      rd("R4", 12'h004);
      // R2 decode
      wr("R2 scaler", 12'h00C, 32'h1234_5678);
      rd("R2 scaler", 12'h00C);
      rd("R2 debug", 12'h010);
      rd("R2 hole", 12'h014);
      rd("R2 byte1", 12'h001);
      rd("R2 alias", 12'hF08);
      wr("R2 hole", 12'h0F4, 32'hFFFF_FFFF);
      rd("R2 ctrl intact", 12'h008);
      // R5 disabled receive
      wr("R5", 12'h008, 32'h0000_0004);
      for (int i = 0; i < 3; i++) idle("R5", 1, 8'h40 + 8'(i));
      rd("R5 status", 12'h004);
      rd("R5 data", 12'h000);
      // R6/R12/R10 receive with irq
      wr("R10", 12'h008, 32'h0000_0005);
      idle("R10", 1, 8'h11);
      idle("R10", 0);
      idle("R10", 1, 8'h22);
      idle("R10", 1, 8'h33);
      rd("R12 status", 12'h004);
      rd("R6 byte3", 12'h003);
      rd("R6", 12'h000);
      rd("R12 status", 12'h004);
      rd("R6 last", 12'h000);
      rd("R12 status", 12'h004);
      rd("R6 empty", 12'h000);
      // R9 transmit
      wr("R9", 12'h008, 32'h0000_000A);
      wr("R9", 12'h000, 32'h1234_56C3);
      idle("R9");
      wr("R9 byte3", 12'h003, 32'h0000_007E);
      wr("R9 no sink", 12'h000, 32'h0000_0055, 0, 0, 0);
      idle("R9");
      wr("R9", 12'h008, 32'h0000_0008);
      wr("R9 disabled", 12'h000, 32'h0000_0066);
      idle("R9");
      // R10 simultaneous events -> one pulse
      wr("R10", 12'h008, 32'h0000_000F);
      wr("R10 both", 12'h000, 32'h0000_00A1, 1, 8'h5A);
      idle("R10");
      idle("R10");
      rd("R6", 12'h000);
      // R8/R7 fill and drain
      wr("R8", 12'h008, 32'h0000_0001);
      for (int i = 0; i < DEPTH; i++) idle("R8", 1, 8'(i * 7));
      idle("R8 full", 1, 8'hEE);
      rd("R12 status", 12'h004);
      for (int i = 0; i < DEPTH - 1; i++) rd("R7 partial", 12'h000);
      idle("R7 still low");
      rd("R7 last", 12'h000);
      idle("R7 rewound", 1, 8'h91);
      // drain and arrive in the same cycle (no rewind)
      rd("R7 drain+push", 12'h000, 1, 8'h92);
      rd("R7", 12'h000);
      rd("R6 empty", 12'h000);
      idle("R7");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         vec++;
         bad++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

endmodule